// File: doc/BRIEF.md
# Key-Guarded Sequence Table Store

This block holds the instruction table that a serial-flash sequence engine walks through when it runs a command. The table is a set of 32-bit words. A register bus writes and reads it through a window of word-aligned addresses. The sequence engine reads it through a separate index port that the bus cannot block.

Bus writes reach the table only while it is unlocked. The lock state changes only through a two-write handshake. The first write puts a fixed key word into the key register. The bus write that comes straight after it must go to the lock control register and carry a lock or an unlock command. A command without a fresh key has no effect, and so does a key that is not followed directly by a command. Software opens the table, fills it, and closes it again. After that, a stray write cannot corrupt a sequence that the engine is running.

Top module: `seqtbl_store`

## Requirements
- R1: After reset the table is unlocked and every word reads back as zero, on both the bus read port and the engine port.
- R2: If bus_rd is high in a cycle, bus_rdata shows the table word selected by bus_addr one cycle later. Table word n sits at byte address 0x310 + 4*n, for n from 0 to 63. For any other address, including misaligned ones and the key and lock registers, bus_rdata reads zero.
- R3: While the table is unlocked, a bus write to 0x310 + 4*n stores bus_wdata in word n. A bus write to any other address changes no table word.
- R4: While the table is locked, bus writes to table addresses are ignored and the stored words keep their values.
- R5: Writing 0x5AF05AF0 to the key register at 0x300 arms the lock control register at 0x304. If the very next bus write goes to 0x304 with value 1, the table locks; with value 2, it unlocks.
- R6: A write to 0x304 when the key register is not armed leaves the lock state unchanged.
- R7: The armed state covers only the single next bus write. Any write that is not itself a correct key write disarms it, so a command that arrives after an intervening write is ignored.
- R8: Writing any value other than 0x5AF05AF0 to 0x300 leaves the key register disarmed.
- R9: An armed write to 0x304 with a value other than 1 or 2 leaves the lock state unchanged and disarms the key register.
- R10: eng_word shows the table word selected by eng_idx one cycle later, whether the table is locked or unlocked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Bus write strobe, one write per high cycle |
| bus_rd | input | 1 | Bus read strobe |
| bus_addr | input | 12 | Byte address for both the read and the write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after bus_rd |
| eng_idx | input | 6 | Table index requested by the sequence engine |
| eng_word | output | 32 | Table word for eng_idx, one cycle later |

## Verification
The assertions check the lock handshake on every cycle:
- the lock state moves only on an armed command of 1 or 2;
- an unarmed or unknown command leaves it unchanged;
- a wrong key write, or any other intervening write, clears the armed state;
- a read outside the table window returns zero.

Some behaviours only the bench's scenarios can show, by reading the table back through the bus and engine ports:
- writes that were ignored while locked;
- data that was stored while unlocked;
- the all-zero contents after reset.

// File: rtl/seqtbl_pkg.sv
package seqtbl_pkg;
   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_KEY  = 2'd1,
      SEL_LOCK = 2'd2,
      SEL_TBL  = 2'd3
   } seqtbl_sel_e;

   localparam logic [31:0] DEF_KEY_WORD = 32'h5AF0_5AF0;
   localparam logic [31:0] DEF_CMD_LOCK = 32'd1;
   localparam logic [31:0] DEF_CMD_OPEN = 32'd2;
endpackage

// File: rtl/seqtbl_addr_dec.sv
module seqtbl_addr_dec
   import seqtbl_pkg::*;
#(
   parameter int ADDR_W   = 12,
   parameter int DEPTH    = 64,
   parameter int IDX_W    = 6,
   parameter int KEY_OFS  = 'h300,
   parameter int LOCK_OFS = 'h304,
   parameter int TBL_BASE = 'h310
) (
   input  logic [ADDR_W-1:0] addr,
   output seqtbl_sel_e       sel,
   output logic [IDX_W-1:0]  idx
);
   localparam logic [ADDR_W-1:0] KEY_A  = ADDR_W'(KEY_OFS);
   localparam logic [ADDR_W-1:0] LOCK_A = ADDR_W'(LOCK_OFS);
   localparam logic [ADDR_W:0]   TBL_LO = (ADDR_W+1)'(TBL_BASE);
   localparam logic [ADDR_W:0]   TBL_HI = (ADDR_W+1)'(TBL_BASE + 4*DEPTH);

   logic [ADDR_W-1:0] offset;
   logic              in_window;

   assign offset    = addr - ADDR_W'(TBL_BASE);
   assign in_window = ({1'b0, addr} >= TBL_LO) && ({1'b0, addr} < TBL_HI);

   always_comb begin
      sel = SEL_NONE;
      idx = offset[IDX_W+1:2];
      if (addr[1:0] == 2'b00) begin
         if (addr == KEY_A)       sel = SEL_KEY;
         else if (addr == LOCK_A) sel = SEL_LOCK;
         else if (in_window)      sel = SEL_TBL;
      end
   end
endmodule

// File: rtl/seqtbl_guard.sv
module seqtbl_guard
   import seqtbl_pkg::*;
#(
   parameter int          DATA_W   = 32,
   parameter logic [31:0] KEY_WORD = DEF_KEY_WORD,
   parameter logic [31:0] CMD_LOCK = DEF_CMD_LOCK,
   parameter logic [31:0] CMD_OPEN = DEF_CMD_OPEN
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  seqtbl_sel_e       sel,
   input  logic [DATA_W-1:0] wdata,
   output logic              locked,
   output logic              armed
);
   logic key_ok;

   assign key_ok = (sel == SEL_KEY) && (wdata == DATA_W'(KEY_WORD));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed  <= 1'b0;
         locked <= 1'b0;
      end else if (wr) begin
         armed <= key_ok;
         if (armed && sel == SEL_LOCK) begin
            if (wdata == DATA_W'(CMD_LOCK))      locked <= 1'b1;
            else if (wdata == DATA_W'(CMD_OPEN)) locked <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/seqtbl_array.sv
module seqtbl_array #(
   parameter int DATA_W  = 32,
   parameter int DEPTH   = 64,
   parameter int IDX_W   = 6,
   parameter bit ENG_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IDX_W-1:0]  widx,
   input  logic [DATA_W-1:0] wdata,
   input  logic [IDX_W-1:0]  bus_idx,
   output logic [DATA_W-1:0] bus_word,
   input  logic [IDX_W-1:0]  eng_idx,
   output logic [DATA_W-1:0] eng_word
);
   logic [DATA_W-1:0] mem [DEPTH];
   logic [DATA_W-1:0] eng_sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (we) begin
         for (int i = 0; i < DEPTH; i++)
            if (widx == IDX_W'(i)) mem[i] <= wdata;
      end
   end

   assign bus_word = (int'(bus_idx) < DEPTH) ? mem[bus_idx] : '0;
   assign eng_sel  = (int'(eng_idx) < DEPTH) ? mem[eng_idx] : '0;

   generate
      if (ENG_REG) begin : g_eng_reg
         logic [DATA_W-1:0] eng_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) eng_q <= '0;
            else        eng_q <= eng_sel;
         end
         assign eng_word = eng_q;
      end else begin : g_eng_comb
         assign eng_word = eng_sel;
      end
   endgenerate
endmodule

// File: rtl/seqtbl_store.sv
module seqtbl_store
   import seqtbl_pkg::*;
#(
   parameter int          DATA_W   = 32,
   parameter int          DEPTH    = 64,
   parameter int          ADDR_W   = 12,
   parameter int          KEY_OFS  = 'h300,
   parameter int          LOCK_OFS = 'h304,
   parameter int          TBL_BASE = 'h310,
   parameter logic [31:0] KEY_WORD = DEF_KEY_WORD,
   parameter logic [31:0] CMD_LOCK = DEF_CMD_LOCK,
   parameter logic [31:0] CMD_OPEN = DEF_CMD_OPEN,
   parameter bit          ENG_REG  = 1'b1,
   localparam int         IDX_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [IDX_W-1:0]  eng_idx,
   output logic [DATA_W-1:0] eng_word
);
   generate
      if (DEPTH < 1)
         $error("seqtbl_store: DEPTH must be at least 1");
      if (DATA_W < 2 || DATA_W > 32)
         $error("seqtbl_store: DATA_W must lie in 2..32");
      if (IDX_W + 2 > ADDR_W)
         $error("seqtbl_store: ADDR_W too narrow for the table");
      if (TBL_BASE + 4*DEPTH > (1 << ADDR_W))
         $error("seqtbl_store: table window exceeds the address space");
      if ((KEY_OFS % 4) != 0 || (LOCK_OFS % 4) != 0 || (TBL_BASE % 4) != 0)
         $error("seqtbl_store: register offsets must be word aligned");
   endgenerate

   seqtbl_sel_e       sel;
   logic [IDX_W-1:0]  idx;
   logic              lock_q;
   logic              armed_q;
   logic              tbl_we;
   logic [DATA_W-1:0] bus_word;
   logic [DATA_W-1:0] rdata_q;

   seqtbl_addr_dec #(
      .ADDR_W(ADDR_W), .DEPTH(DEPTH), .IDX_W(IDX_W),
      .KEY_OFS(KEY_OFS), .LOCK_OFS(LOCK_OFS), .TBL_BASE(TBL_BASE)
   ) u_dec (
      .addr(bus_addr), .sel(sel), .idx(idx)
   );

   seqtbl_guard #(
      .DATA_W(DATA_W), .KEY_WORD(KEY_WORD),
      .CMD_LOCK(CMD_LOCK), .CMD_OPEN(CMD_OPEN)
   ) u_guard (
      .clk(clk), .rst_n(rst_n), .wr(bus_wr), .sel(sel),
      .wdata(bus_wdata), .locked(lock_q), .armed(armed_q)
   );

   assign tbl_we = bus_wr && (sel == SEL_TBL) && !lock_q;

   seqtbl_array #(
      .DATA_W(DATA_W), .DEPTH(DEPTH), .IDX_W(IDX_W), .ENG_REG(ENG_REG)
   ) u_arr (
      .clk(clk), .rst_n(rst_n), .we(tbl_we), .widx(idx), .wdata(bus_wdata),
      .bus_idx(idx), .bus_word(bus_word),
      .eng_idx(eng_idx), .eng_word(eng_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        rdata_q <= '0;
      else if (bus_rd && sel == SEL_TBL) rdata_q <= bus_word;
      else                               rdata_q <= '0;
   end

   assign bus_rdata = rdata_q;
endmodule

// File: rtl/seqtbl_store_chk.sv
module seqtbl_store_chk #(
   parameter int          DATA_W   = 32,
   parameter int          DEPTH    = 64,
   parameter int          ADDR_W   = 12,
   parameter int          KEY_OFS  = 'h300,
   parameter int          LOCK_OFS = 'h304,
   parameter int          TBL_BASE = 'h310,
   parameter logic [31:0] KEY_WORD = 32'h5AF0_5AF0,
   parameter logic [31:0] CMD_LOCK = 32'd1,
   parameter logic [31:0] CMD_OPEN = 32'd2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              locked,
   input logic              armed
);
   logic key_w, good_key_w, lock_w, tbl_addr;

   assign key_w      = bus_wr && (bus_addr == ADDR_W'(KEY_OFS));
   assign good_key_w = key_w && (bus_wdata == DATA_W'(KEY_WORD));
   assign lock_w     = bus_wr && (bus_addr == ADDR_W'(LOCK_OFS));
   assign tbl_addr   = (bus_addr[1:0] == 2'b00)
                    && (int'(bus_addr) >= TBL_BASE)
                    && (int'(bus_addr) < TBL_BASE + 4*DEPTH);

   assert_rd_outside_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !tbl_addr) |=> (bus_rdata == '0));

   assert_lock_needs_key_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked) |-> $past(armed && lock_w && bus_wdata == DATA_W'(CMD_LOCK)));

   assert_open_needs_key_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(locked) |-> $past(armed && lock_w && bus_wdata == DATA_W'(CMD_OPEN)));

   assert_unarmed_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_w && !armed) |=> $stable(locked));

   assert_single_shot_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && bus_wr && !good_key_w) |=> !armed);

   assert_wrong_key_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (key_w && !good_key_w) |=> !armed);

   assert_bad_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && lock_w && bus_wdata != DATA_W'(CMD_LOCK)
       && bus_wdata != DATA_W'(CMD_OPEN)) |=> ($stable(locked) && !armed));
endmodule

bind seqtbl_store seqtbl_store_chk #(
   .DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W),
   .KEY_OFS(KEY_OFS), .LOCK_OFS(LOCK_OFS), .TBL_BASE(TBL_BASE),
   .KEY_WORD(KEY_WORD), .CMD_LOCK(CMD_LOCK), .CMD_OPEN(CMD_OPEN)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
   .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
   .locked(lock_q), .armed(armed_q)
);

// File: tb/seqtbl_store_bench.sv
`timescale 1ns/1ps
module seqtbl_store_bench;
   localparam int          DEPTH = 64;
   localparam logic [11:0] KEY_A = 12'h300;
   localparam logic [11:0] LCK_A = 12'h304;
   localparam int          BASE  = 'h310;
   localparam logic [31:0] KEYV  = 32'h5AF0_5AF0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [5:0]  eng_idx = '0;
   logic [31:0] eng_word;

   int          vectors = 0;
   int          fails = 0;
   bit          done = 1'b0;

   logic [31:0] exp_mem [DEPTH];
   bit          exp_locked = 1'b0;
   bit          exp_armed = 1'b0;

   always #2 clk = ~clk;

   seqtbl_store u_seqtbl_store (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .eng_idx(eng_idx), .eng_word(eng_word)
   );

   function automatic logic [11:0] waddr(int n);
      return 12'(BASE + 4*n);
   endfunction

   function automatic bit is_tbl(logic [11:0] a);
      return (a[1:0] == 2'b00) && (int'(a) >= BASE) && (int'(a) < BASE + 4*DEPTH);
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic model_write(logic [11:0] a, logic [31:0] d);
      if (exp_armed && a == LCK_A) begin
         if (d == 32'd1)      exp_locked = 1'b1;
         else if (d == 32'd2) exp_locked = 1'b0;
      end
      if (is_tbl(a) && !exp_locked) exp_mem[(int'(a) - BASE) / 4] = d;
      exp_armed = (a == KEY_A) && (d == KEYV);
   endtask

   task automatic bus_write(logic [11:0] a, logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
      model_write(a, d);
   endtask

   task automatic read_chk(string req, int n);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = waddr(n);
      @(negedge clk);
      bus_rd = 1'b0;
      chk(req, bus_rdata, exp_mem[n]);
   endtask

   task automatic read_addr_zero(string req, logic [11:0] a);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      @(negedge clk);
      bus_rd = 1'b0;
      chk(req, bus_rdata, 32'h0);
   endtask

   task automatic eng_chk(string req, int n);
      @(negedge clk);
      eng_idx = 6'(n);
      @(negedge clk);
      chk(req, eng_word, exp_mem[n]);
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < DEPTH; i++) exp_mem[i] = '0;
      void'($urandom(32'h0BADCAFE));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset contents and unlocked state
      read_chk("R1", 0);
      read_chk("R1", 63);
      eng_chk("R1", 17);
      bus_write(waddr(1), 32'h1111_0001);
      read_chk("R1", 1);

      // R3: unlocked writes, boundary words, misaligned and outside
      bus_write(waddr(3), 32'hA5A5_0003);
      read_chk("R3", 3);
      bus_write(waddr(63), 32'hFFFF_003F);
      read_chk("R3", 63);
      bus_write(waddr(2) + 12'd1, 32'hDEAD_0002);
      read_chk("R3", 2);
      bus_write(12'(BASE + 4*DEPTH), 32'hDEAD_0040);
      read_chk("R3", 0);

      // R2: non-table reads give zero
      read_addr_zero("R2", KEY_A);
      read_addr_zero("R2", waddr(3) + 12'd2);
      read_addr_zero("R2", 12'h30C);

      // R6: lock command without a key
      bus_write(LCK_A, 32'd1);
      bus_write(waddr(4), 32'h4444_0004);
      read_chk("R6", 4);

      // R5 and R4: lock, then writes ignored
      bus_write(KEY_A, KEYV);
      bus_write(LCK_A, 32'd1);
      bus_write(waddr(4), 32'hBAD0_0004);
      read_chk("R4", 4);
      bus_write(waddr(0), 32'hBAD0_0000);
      read_chk("R4", 0);
      eng_chk("R10", 4);
      eng_chk("R10", 63);

      // R7: intervening write disarms
      bus_write(KEY_A, KEYV);
      bus_write(waddr(9), 32'h9999_9999);
      bus_write(LCK_A, 32'd2);
      bus_write(waddr(5), 32'h5555_0005);
      read_chk("R7", 5);

      // R8: wrong key
      bus_write(KEY_A, KEYV ^ 32'h1);
      bus_write(LCK_A, 32'd2);
      bus_write(waddr(5), 32'h5555_0005);
      read_chk("R8", 5);
      bus_write(KEY_A, KEYV);
      bus_write(KEY_A, 32'h0);
      bus_write(LCK_A, 32'd2);
      bus_write(waddr(5), 32'h5555_0005);
      read_chk("R8", 5);

      // R9: unknown command disarms
      bus_write(KEY_A, KEYV);
      bus_write(LCK_A, 32'd3);
      bus_write(LCK_A, 32'd2);
      bus_write(waddr(6), 32'h6666_0006);
      read_chk("R9", 6);

      // R5: repeated key keeps armed, unlock works
      bus_write(KEY_A, KEYV);
      bus_write(KEY_A, KEYV);
      bus_write(LCK_A, 32'd2);
      bus_write(waddr(6), 32'h6666_0006);
      read_chk("R5", 6);
      eng_chk("R10", 6);

      // Random mix
      for (int it = 0; it < 1500; it++) begin
         int op;
         op = $urandom_range(0, 9);
         case (op)
            0, 1, 2: begin
               logic [11:0] a;
               a = waddr($urandom_range(0, DEPTH-1));
               if ($urandom_range(0, 7) == 0) a = a + 12'($urandom_range(1, 3));
               bus_write(a, $urandom());
            end
            3: begin
               bus_write(KEY_A, ($urandom_range(0, 3) != 0) ? KEYV : $urandom());
               if ($urandom_range(0, 1) == 1)
                  bus_write(LCK_A, 32'($urandom_range(0, 3)));
            end
            4: bus_write(LCK_A, 32'($urandom_range(0, 3)));
            5: bus_write(12'($urandom_range(0, 'h103) * 4), $urandom());
            6, 7: read_chk("R4", $urandom_range(0, DEPTH-1));
            default: eng_chk("R10", $urandom_range(0, DEPTH-1));
         endcase
      end

      for (int n = 0; n < DEPTH; n++) read_chk("R3", n);
      for (int n = 0; n < DEPTH; n++) eng_chk("R10", n);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule